// File: doc/BRIEF.md
# Programmable Two-State Pin Event Machine

This block watches one of two clocked pin inputs and reacts to its edges and levels through a small table of rules. Each clock it builds a two-bit condition from the present and the previous sample of the chosen pin. It pairs that condition with a single state bit and picks one of eight 5-bit opcodes. Four opcodes sit in configuration word X, used while the state bit is 0. The other four sit in word Y, used while it is 1.

An opcode can flip the state bit, advance a saturating step counter, issue a SIGNAL that advances a signal counter and may raise the event flag, clear both counters, and copy the step counter into a result register. Software loads X and Y to set up a pattern detector, divider, edge counter or pulse timer. It then waits for the event flag and reads the result, which drops the flag.

The option bits in X choose the pin and the event rate. The event can come from every SIGNAL, from every eighth SIGNAL, or from the signal and step counters chained together.

Top module: `pin_evt_machine`

## Requirements
- R1: After reset the event flag, step counter, signal counter and result are all zero.
- R2: The condition index is {current, previous} sample of the chosen pin, and it selects the opcode field [4:0] for 00 (held low), [9:5] for 01 (falling), [14:10] for 10 (rising) or [19:15] for 11 (held high). A pin change takes effect on the counters two clock edges after it is sampled.
- R3: Bit 26 of X selects the watched pin: 0 picks pin A and 1 picks pin B. Activity on the other pin has no effect.
- R4: Opcode bit 0 toggles the state bit. In state 0 the opcodes are read from X and in state 1 from Y.
- R5: Opcode bit 1 advances the step counter by one. The counter saturates at 31 and never wraps.
- R6: Opcode bit 2 (SIGNAL) advances the 3-bit signal counter, which wraps modulo 8. With X bit 27 at 0 every SIGNAL raises the event flag. With X bit 27 at 1 only the SIGNAL that wraps the counter from 7 to 0 raises it.
- R7: With X bit 28 at 1 the counters are chained: each wrap of the signal counter advances the step counter. The flag rises only on a wrap that occurs while the step counter is already at 31, which first happens on the 256th SIGNAL.
- R8: Opcode bit 3 clears both counters and takes priority over any increment in the same cycle.
- R9: Opcode bit 4 copies the step counter value into the result output.
- R10: Asserting the result read strobe clears the event flag.
- R11: A write to either configuration word clears the state bit, both counters and the event flag.
- R12: An all-zero opcode changes nothing: counters, flag and result hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_x_data | input | 32 | Rule word for state 0 plus option bits |
| cfg_x_we | input | 1 | Write strobe for word X |
| cfg_y_data | input | 32 | Rule word for state 1 |
| cfg_y_we | input | 1 | Write strobe for word Y |
| pin_a | input | 1 | Pin input A |
| pin_b | input | 1 | Pin input B |
| result_rd | input | 1 | Result read strobe, clears the event flag |
| event_flag | output | 1 | Event pending |
| step_count | output | 5 | Saturating step counter |
| sig_count | output | 3 | Signal counter |
| result_val | output | 5 | Latched step counter value |

## Verification
Single pulses exercise the rising and falling table slots, and long highs exercise the held-high slot. Idle low time shows that a NOP slot leaves everything unchanged. Pulse trains of 5 and 40 separate plain counting from saturation. A run of 8 SIGNALs tells the divide-by-one rate from the divide-by-eight rate. A run of 256 SIGNALs in chained mode, checked at 255 and again at 256, separates a correct carry chain from an off-by-one. Pulses on the unselected pin, a toggle into the Y table, and configuration writes made mid-count show which pin and which table drive the result, and that the clear took effect.

// File: rtl/pin_evt_pkg.sv
// Shared definitions for the pin event machine: opcode layout and the
// positions of the option bits in configuration word X.
package pin_evt_pkg;
    localparam int OP_W      = 5;
    localparam int N_COND    = 4;
    localparam int RULE_W    = OP_W * N_COND;
    localparam int OPT_SEL_B = 26;
    localparam int OPT_DIV8  = 27;
    localparam int OPT_CHAIN = 28;

    typedef struct packed {
        logic latch;   // bit 4: copy step counter to result
        logic clr;     // bit 3: clear both counters
        logic sig;     // bit 2: SIGNAL
        logic inc;     // bit 1: advance step counter
        logic tog;     // bit 0: toggle state
    } evt_op_t;

    typedef struct packed {
        logic chain;
        logic div8;
        logic sel_b;
    } evt_opt_t;
endpackage

// File: rtl/pin_evt_sampler.sv
// Clocks the pin inputs and keeps one previous sample of each, then forms
// the two-bit condition {current, previous} of the selected pin.
// Assumes the pins may be asynchronous; only registered copies are used.
module pin_evt_sampler #(
    parameter int N_PINS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins,
    input  logic              sel,
    output logic [1:0]        cond
);
    logic [N_PINS-1:0] cur_q;
    logic [N_PINS-1:0] prev_q;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        // Register the present sample and its predecessor for one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q[g]  <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                cur_q[g]  <= pins[g];
                prev_q[g] <= cur_q[g];
            end
        end
    end

    // Pick the watched pin and form its condition index.
    always_comb begin
        cond = {cur_q[sel], prev_q[sel]};
    end
endmodule

// File: rtl/pin_evt_decode.sv
// Chooses the rule word by state and extracts the opcode for the present
// condition. Purely combinational.
module pin_evt_decode
    import pin_evt_pkg::*;
(
    input  logic [RULE_W-1:0] rule_x,
    input  logic [RULE_W-1:0] rule_y,
    input  logic              state,
    input  logic [1:0]        cond,
    output evt_op_t           op
);
    logic [RULE_W-1:0] rule;

    // Select the table for the current state and slice out one field.
    always_comb begin
        rule = state ? rule_y : rule_x;
        op   = evt_op_t'(rule[cond*OP_W +: OP_W]);
    end
endmodule

// File: rtl/pin_evt_counters.sv
// Executes one opcode per clock: state toggle, saturating step counter,
// wrapping signal counter, event flag and result latch.
// Assumes cfg_clr comes from a configuration write and overrides all else.
module pin_evt_counters
    import pin_evt_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int SIG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  evt_op_t          op,
    input  evt_opt_t         opt,
    input  logic             cfg_clr,
    input  logic             rd,
    output logic             state,
    output logic [CNT_W-1:0] step_q,
    output logic [SIG_W-1:0] sig_q,
    output logic [CNT_W-1:0] result_q,
    output logic             flag_q
);
    localparam logic [CNT_W-1:0] STEP_MAX = {CNT_W{1'b1}};
    localparam logic [SIG_W-1:0] SIG_MAX  = {SIG_W{1'b1}};

    logic sig_wrap;
    logic step_adv;
    logic event_now;

    // Work out the carries and the event of this cycle.
    always_comb begin
        sig_wrap = op.sig && (sig_q == SIG_MAX);
        step_adv = op.inc || (opt.chain && sig_wrap);
        if (opt.chain)
            event_now = sig_wrap && (step_q == STEP_MAX);
        else if (opt.div8)
            event_now = sig_wrap;
        else
            event_now = op.sig;
    end

    // State bit: toggled by opcode, cleared by a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_clr)
            state <= 1'b0;
        else if (op.tog)
            state <= ~state;
    end

    // Step counter: clear wins, otherwise saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_clr || op.clr)
            step_q <= '0;
        else if (step_adv && step_q != STEP_MAX)
            step_q <= step_q + 1'b1;
    end

    // Signal counter: clear wins, otherwise wrap-around increment.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_clr || op.clr)
            sig_q <= '0;
        else if (op.sig)
            sig_q <= sig_q + 1'b1;
    end

    // Event flag: set by an event, dropped by a read or configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_clr)
            flag_q <= 1'b0;
        else if (event_now)
            flag_q <= 1'b1;
        else if (rd)
            flag_q <= 1'b0;
    end

    // Result register: captures the step counter on a latch opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (op.latch)
            result_q <= step_q;
    end
endmodule

// File: rtl/pin_evt_machine.sv
// Top of the pin event machine. Holds the two configuration words, wires
// the sampler, decoder and counters. Rule fields live in bits [19:0] of
// each word; options live in bits [28:26] of word X.
module pin_evt_machine
    import pin_evt_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int SIG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_x_data,
    input  logic             cfg_x_we,
    input  logic [31:0]      cfg_y_data,
    input  logic             cfg_y_we,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             result_rd,
    output logic             event_flag,
    output logic [CNT_W-1:0] step_count,
    output logic [SIG_W-1:0] sig_count,
    output logic [CNT_W-1:0] result_val
);
    logic [RULE_W-1:0] rule_x_q;
    logic [RULE_W-1:0] rule_y_q;
    evt_opt_t          opt_q;
    logic [1:0]        cond;
    logic              state;
    logic              cfg_clr;
    evt_op_t           op;
    logic [11:0]       unused_cfg_bits;

    assign cfg_clr         = cfg_x_we || cfg_y_we;
    assign unused_cfg_bits = {cfg_x_data[31:29], cfg_x_data[25:20],
                              cfg_y_data[31:29], cfg_y_data[28:26]};

    // Configuration storage for the state-0 table and the options.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rule_x_q <= '0;
            opt_q    <= '0;
        end else if (cfg_x_we) begin
            rule_x_q <= cfg_x_data[RULE_W-1:0];
            opt_q    <= '{chain: cfg_x_data[OPT_CHAIN],
                          div8:  cfg_x_data[OPT_DIV8],
                          sel_b: cfg_x_data[OPT_SEL_B]};
        end
    end

    // Configuration storage for the state-1 table.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rule_y_q <= '0;
        else if (cfg_y_we)
            rule_y_q <= cfg_y_data[RULE_W-1:0];
    end

    pin_evt_sampler #(.N_PINS(2)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({pin_b, pin_a}),
        .sel   (opt_q.sel_b),
        .cond  (cond)
    );

    pin_evt_decode u_decode (
        .rule_x (rule_x_q),
        .rule_y (rule_y_q),
        .state  (state),
        .cond   (cond),
        .op     (op)
    );

    pin_evt_counters #(.CNT_W(CNT_W), .SIG_W(SIG_W)) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .opt      (opt_q),
        .cfg_clr  (cfg_clr),
        .rd       (result_rd),
        .state    (state),
        .step_q   (step_count),
        .sig_q    (sig_count),
        .result_q (result_val),
        .flag_q   (event_flag)
    );
endmodule

// File: rtl/pin_evt_machine_chk.sv
// Port-level properties of the pin event machine, bound to the top.
module pin_evt_machine_chk #(
    parameter int CNT_W = 5,
    parameter int SIG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_x_we,
    input logic             cfg_y_we,
    input logic             event_flag,
    input logic [CNT_W-1:0] step_count,
    input logic [SIG_W-1:0] sig_count,
    input logic [CNT_W-1:0] result_val
);
    localparam logic [CNT_W-1:0] STEP_MAX = {CNT_W{1'b1}};

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_count == STEP_MAX && !cfg_x_we && !cfg_y_we) |=>
        (step_count == STEP_MAX || step_count == '0));

    // R5
    step_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_x_we && !cfg_y_we) |=>
        (step_count == $past(step_count) ||
         step_count == $past(step_count) + 1'b1 || step_count == '0));

    // R6
    sig_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_x_we && !cfg_y_we) |=>
        (sig_count == $past(sig_count) ||
         sig_count == $past(sig_count) + 1'b1 || sig_count == '0));

    // R11
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_x_we || cfg_y_we) |=>
        (step_count == '0 && sig_count == '0 && !event_flag));

    // R9
    latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_val != $past(result_val)) |-> (result_val == $past(step_count)));
endmodule

bind pin_evt_machine pin_evt_machine_chk #(.CNT_W(CNT_W), .SIG_W(SIG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_x_we   (cfg_x_we),
    .cfg_y_we   (cfg_y_we),
    .event_flag (event_flag),
    .step_count (step_count),
    .sig_count  (sig_count),
    .result_val (result_val)
);

// File: tb/pin_evt_machine_bench.sv
// Scenario bench for the pin event machine; expected values are counted
// from the requirements.
module pin_evt_machine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_x_data = '0;
    logic        cfg_x_we = 1'b0;
    logic [31:0] cfg_y_data = '0;
    logic        cfg_y_we = 1'b0;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    logic        result_rd = 1'b0;
    logic        event_flag;
    logic [4:0]  step_count;
    logic [2:0]  sig_count;
    logic [4:0]  result_val;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [4:0] TOG = 5'h01, INC = 5'h02, SIG = 5'h04,
                           CLR = 5'h08, LAT = 5'h10;

    always #2 clk = ~clk;

    pin_evt_machine u_pin_evt_machine (.*);

    function automatic logic [31:0] mk(input logic [4:0] hold_lo, input logic [4:0] fall,
                                       input logic [4:0] rise, input logic [4:0] hold_hi,
                                       input logic sel_b, input logic div8, input logic chain);
        return {3'b0, chain, div8, sel_b, 6'b0, hold_hi, rise, fall, hold_lo};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] x, input logic [31:0] y);
        cfg_x_data = x; cfg_y_data = y; cfg_x_we = 1'b1; cfg_y_we = 1'b1;
        @(negedge clk);
        cfg_x_we = 1'b0; cfg_y_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input bit on_b);
        if (on_b) pin_b = 1'b1; else pin_a = 1'b1;
        @(negedge clk);
        pin_a = 1'b0; pin_b = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse(1'b0);
    endtask

    task automatic read_result();
        result_rd = 1'b1;
        @(negedge clk);
        result_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 flag", event_flag, 0);
        check("R1 step", step_count, 0);
        check("R1 sig", sig_count, 0);
        check("R1 result", result_val, 0);

        // R2 R5 rising slot counts pulses
        load(mk(0, 0, INC, 0, 0, 0, 0), 0);
        pulses(5);
        check("R2 rise count", step_count, 5);
        // R12 idle low with NOP slot changes nothing
        repeat (10) @(negedge clk);
        check("R12 step hold", step_count, 5);
        check("R12 flag hold", event_flag, 0);
        // R5 saturation
        pulses(35);
        check("R5 saturate", step_count, 31);

        // R11 configuration write clears counters
        load(mk(0, INC, 0, 0, 0, 0, 0), 0);
        check("R11 step cleared", step_count, 0);
        // R2 falling slot
        pulses(4);
        check("R2 fall count", step_count, 4);

        // R3 pin B selected, pin A ignored
        load(mk(0, 0, INC, 0, 1, 0, 0), 0);
        pulses(3);
        check("R3 pin A ignored", step_count, 0);
        for (int i = 0; i < 2; i++) pulse(1'b1);
        check("R3 pin B counted", step_count, 2);

        // R4 toggle into table Y, which signals
        load(mk(0, 0, TOG | INC, 0, 0, 0, 0), mk(0, 0, SIG, 0, 0, 0, 0));
        pulse(1'b0);
        check("R4 X used in state 0", step_count, 1);
        check("R4 no event yet", event_flag, 0);
        pulses(2);
        check("R4 Y used in state 1", step_count, 1);
        check("R6 every SIGNAL flags", event_flag, 1);
        check("R6 sig count", sig_count, 2);
        // R10 read clears flag
        read_result();
        @(negedge clk);
        check("R10 flag cleared", event_flag, 0);
        // R11 write clears state: next rise uses X again
        load(mk(0, 0, TOG | INC, 0, 0, 0, 0), mk(0, 0, SIG, 0, 0, 0, 0));
        pulse(1'b0);
        check("R11 state cleared", step_count, 1);
        check("R11 sig cleared", sig_count, 0);

        // R6 divide by eight
        load(mk(0, 0, SIG, 0, 0, 1, 0), 0);
        pulses(7);
        check("R6 div8 no flag at 7", event_flag, 0);
        check("R6 div8 count 7", sig_count, 7);
        pulse(1'b0);
        check("R6 div8 flag at 8", event_flag, 1);
        check("R6 div8 wrapped", sig_count, 0);

        // R9 latch on falling edge after rising increment
        load(mk(0, LAT, INC, 0, 0, 0, 0), 0);
        pulses(3);
        check("R9 latched value", result_val, 3);

        // R8 held-high slot clears, overriding the rise increment
        load(mk(0, 0, INC | SIG, CLR | INC, 0, 0, 0), 0);
        pulses(2);
        check("R8 before clear", step_count, 2);
        pin_a = 1'b1;
        repeat (3) @(negedge clk);
        pin_a = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 step cleared", step_count, 0);
        check("R8 sig cleared", sig_count, 0);

        // R7 chained counters
        load(mk(0, 0, SIG, 0, 0, 0, 1), 0);
        pulses(255);
        check("R7 no flag at 255", event_flag, 0);
        check("R7 step at 255", step_count, 31);
        check("R7 sig at 255", sig_count, 7);
        pulse(1'b0);
        check("R7 flag at 256", event_flag, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule